// File: doc/BRIEF.md
# Cascade Result Serializer with Delayed Summation

This block sits at the tail of a multiply-accumulate stage that is one link in a chain of identical stages. Each data-input cycle it receives a 24-bit partial sum from the previous stage over a 12-bit cascade port, as two halves with the low half first. It holds that word back for a fixed number of data-input cycles, then adds it to the local 24-bit accumulator result. The sum goes out as two 12-bit halves on the output port, which feeds the next stage's cascade port.

A one-clock pulse on `slot_i` opens a data-input cycle. In that clock `acc_i` carries the local result and `casc_i` carries the low cascade half. In the following clock `casc_i` carries the high half. The delay line is a circular buffer held in an inferred RAM. Its contents are undefined until `DEPTH` cascade words have been written.

The output strobe `outrdy_o` drops while the low half is on `dout_o` and rises when the high half appears. The high half then stays on the port until the next cycle begins. Two host-readable registers capture the full result on that rising edge. A signed overflow in the final addition raises a one-clock error pulse.

Top module: `cascade_sum_serializer`

## Requirements
- R1: While `rst` is high at a clock edge and after that edge, `dout_o` is 0, `outrdy_o` is 1, `res_lo_o` and `res_hi_o` are 0, and `ovf_o` is 0.
- R2: A slot is accepted when `slot_i` is 1 and `outrdy_o` is 1. In the clock after an accepted slot, `dout_o` carries bits [11:0] of the sum and `outrdy_o` is 0 for exactly that one clock.
- R3: Two clocks after an accepted slot, `dout_o` carries bits [23:12] of the sum and `outrdy_o` is 1. In the same clock `res_lo_o` and `res_hi_o` hold bits [11:0] and [23:12] of the sum.
- R4: With no accepted slot, `outrdy_o` stays 1 and `dout_o` keeps the last high half.
- R5: The cascade word is assembled from two samples of `casc_i`. The first sample, taken in the slot clock, gives bits [11:0]. The second, taken in the clock after, gives bits [23:12].
- R6: The sum is `acc_i` plus the cascade word assembled `DEPTH` accepted slots earlier, modulo 2^24. This holds once `DEPTH` words have been written.
- R7: `ovf_o` is 1 for exactly the clock in which the low half of a sum is shown. It is 1 only when `acc_i` and the delayed word share a sign bit and the 24-bit sum has the other sign.
- R8: A `slot_i` pulse while `outrdy_o` is 0 is ignored. It starts no output sequence and writes no word into the delay line, so later sums still pair each result with the word from `DEPTH` accepted slots before it.
- R9: `res_lo_o` and `res_hi_o` change only on the clock in which `outrdy_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_i | input | 1 | Opens a data-input cycle |
| acc_i | input | 2*HALF_W | Local accumulator result, valid in the slot clock |
| casc_i | input | HALF_W | Cascade half word: low half in the slot clock, high half in the next clock |
| dout_o | output | HALF_W | Serialized sum, low half then high half |
| outrdy_o | output | 1 | Low during the low half, high once the high half is shown |
| res_lo_o | output | HALF_W | Latched low half of the last result |
| res_hi_o | output | HALF_W | Latched high half of the last result |
| ovf_o | output | 1 | One-clock pulse on signed overflow of the sum |

## Verification
Two events can fall in the same clock:
- writing the high cascade half of one data-input cycle into the delay line;
- reading the oldest delay-line entry for the next cycle.

The bench provokes this by starting slots back to back, with no idle clock between them, as well as with gaps of one and two clocks. Every sum is compared with the accumulator value plus the word the bench itself recorded `DEPTH` accepted slots earlier. A wrong pairing therefore shows up as a wrong sum.

The bench also holds `slot_i` high through the high-half clock. That pulse lands in the same clock as a delay-line write, and it must not shift the pairing.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_HALF_W_DEF = 12;
  localparam int CS_DEPTH_DEF  = 32;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HIGH = 1'b1
  } cs_phase_e;
endpackage

// File: rtl/cs_deser.sv
module cs_deser
  import cs_pkg::*;
#(
  parameter int HALF_W = CS_HALF_W_DEF,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_i,
  input  logic [HALF_W-1:0] casc_i,
  output logic              take_o,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  cs_phase_e         ph_q;
  logic [HALF_W-1:0] lo_q;

  assign take_o = slot_i && (ph_q == PH_IDLE);
  assign push_o = (ph_q == PH_HIGH);
  assign word_o = {casc_i, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
      lo_q <= '0;
    end else begin
      ph_q <= take_o ? PH_HIGH : PH_IDLE;
      if (take_o) lo_q <= casc_i;
    end
  end
endmodule

// File: rtl/cs_delay.sv
module cs_delay #(
  parameter int WORD_W = 24,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] tail_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q;
  logic [AW-1:0]     wptr_inc;
  logic [AW-1:0]     raddr;

  assign wptr_inc = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
  // read the slot that becomes oldest once this write lands
  assign raddr    = push_i ? wptr_inc : wptr_q;

  always_ff @(posedge clk) begin
    if (push_i) mem[wptr_q] <= word_i;
    tail_o <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst)         wptr_q <= '0;
    else if (push_i) wptr_q <= wptr_inc;
  end
endmodule

// File: rtl/cs_adder.sv
module cs_adder #(
  parameter int WORD_W = 24
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              ovf_o
);
  always_comb begin
    sum_o = a_i + b_i;
    ovf_o = (a_i[WORD_W-1] == b_i[WORD_W-1]) &&
            (sum_o[WORD_W-1] != a_i[WORD_W-1]);
  end
endmodule

// File: rtl/cs_serial.sv
module cs_serial #(
  parameter int HALF_W = 12,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [WORD_W-1:0] sum_i,
  input  logic              ovf_i,
  output logic [HALF_W-1:0] dout_o,
  output logic              outrdy_o,
  output logic [HALF_W-1:0] res_lo_o,
  output logic [HALF_W-1:0] res_hi_o,
  output logic              ovf_o
);
  logic [HALF_W-1:0] lo_q;
  logic [HALF_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o   <= '0;
      outrdy_o <= 1'b1;
      res_lo_o <= '0;
      res_hi_o <= '0;
      ovf_o    <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      ovf_o <= 1'b0;
      if (take_i) begin
        dout_o   <= sum_i[HALF_W-1:0];
        outrdy_o <= 1'b0;
        lo_q     <= sum_i[HALF_W-1:0];
        hi_q     <= sum_i[WORD_W-1:HALF_W];
        ovf_o    <= ovf_i;
      end else if (!outrdy_o) begin
        dout_o   <= hi_q;
        outrdy_o <= 1'b1;
        res_lo_o <= lo_q;
        res_hi_o <= hi_q;
      end
    end
  end
endmodule

// File: rtl/cascade_sum_serializer.sv
module cascade_sum_serializer
  import cs_pkg::*;
#(
  parameter int HALF_W = CS_HALF_W_DEF,
  parameter int DEPTH  = CS_DEPTH_DEF,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [HALF_W-1:0] casc_i,
  output logic [HALF_W-1:0] dout_o,
  output logic              outrdy_o,
  output logic [HALF_W-1:0] res_lo_o,
  output logic [HALF_W-1:0] res_hi_o,
  output logic              ovf_o
);
  logic              take;
  logic              push;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] tail;
  logic [WORD_W-1:0] sum;
  logic              ovf;

  cs_deser #(.HALF_W(HALF_W)) u_deser (
    .clk(clk), .rst(rst), .slot_i(slot_i), .casc_i(casc_i),
    .take_o(take), .push_o(push), .word_o(word)
  );

  cs_delay #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_delay (
    .clk(clk), .rst(rst), .push_i(push), .word_i(word), .tail_o(tail)
  );

  cs_adder #(.WORD_W(WORD_W)) u_add (
    .a_i(acc_i), .b_i(tail), .sum_o(sum), .ovf_o(ovf)
  );

  cs_serial #(.HALF_W(HALF_W)) u_ser (
    .clk(clk), .rst(rst), .take_i(take), .sum_i(sum), .ovf_i(ovf),
    .dout_o(dout_o), .outrdy_o(outrdy_o), .res_lo_o(res_lo_o),
    .res_hi_o(res_hi_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/cs_chk.sv
module cs_chk #(
  parameter int HALF_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_i,
  input logic [HALF_W-1:0] dout_o,
  input logic              outrdy_o,
  input logic [HALF_W-1:0] res_lo_o,
  input logic [HALF_W-1:0] res_hi_o,
  input logic              ovf_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (outrdy_o && !ovf_o && dout_o == '0 && res_lo_o == '0 && res_hi_o == '0));

  p_low_after_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (slot_i && outrdy_o) |=> !outrdy_o);

  p_low_one_clock_r2: assert property (@(posedge clk) disable iff (rst)
    !outrdy_o |=> outrdy_o);

  p_results_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(outrdy_o) |-> (res_hi_o == dout_o && res_lo_o == $past(dout_o)));

  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (outrdy_o && !slot_i) |=> (outrdy_o && $stable(dout_o)));

  p_ovf_with_low_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> !outrdy_o);

  p_regs_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !$rose(outrdy_o) |-> ($stable(res_lo_o) && $stable(res_hi_o)));
endmodule

bind cascade_sum_serializer cs_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .slot_i(slot_i), .dout_o(dout_o),
  .outrdy_o(outrdy_o), .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .ovf_o(ovf_o)
);

// File: tb/sim_cascade_sum_serializer.sv
module sim_cascade_sum_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 12;
  localparam int WW = 24;
  localparam int DEPTH = 4;
  localparam int NSLOT = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slot_i = 1'b0;
  logic [WW-1:0] acc_i = '0;
  logic [HW-1:0] casc_i = '0;
  logic [HW-1:0] dout_o;
  logic          outrdy_o;
  logic [HW-1:0] res_lo_o;
  logic [HW-1:0] res_hi_o;
  logic          ovf_o;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] hist [0:NSLOT-1];
  logic [HW-1:0] prev_lo, prev_hi;

  cascade_sum_serializer #(.HALF_W(HW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .slot_i(slot_i), .acc_i(acc_i), .casc_i(casc_i),
    .dout_o(dout_o), .outrdy_o(outrdy_o), .res_lo_o(res_lo_o),
    .res_hi_o(res_hi_o), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] acc_val(input int n);
    int v = n * 32'h1F3A57 + 32'h0A1B2C;
    if (n == DEPTH + 2) return 24'h7FFFFF;
    if (n == DEPTH + 3) return 24'h800000;
    if (n == DEPTH + 4) return 24'h000001;
    if (n == DEPTH + 5) return 24'h800000;
    return v[WW-1:0];
  endfunction

  function automatic logic [WW-1:0] casc_val(input int n);
    int v = (n * 32'h0C3D29) ^ 32'h5A5A5A;
    if (n == 2) return 24'h000001;
    if (n == 3) return 24'h800000;
    if (n == 4) return 24'hFFFFFF;
    if (n == 5) return 24'h7FFFFF;
    return v[WW-1:0];
  endfunction

  // one accepted slot n; hold keeps slot_i high in the high-half clock (R8)
  task automatic run_slot(input int n, input int gap, input logic hold);
    logic [WW-1:0] a, c, s;
    logic          ov;
    logic          primed;
    a = acc_val(n);
    c = casc_val(n);
    hist[n] = c;
    primed = (n >= DEPTH);
    s = primed ? a + hist[n - DEPTH] : '0;
    ov = primed && (a[WW-1] == hist[n - DEPTH][WW-1]) && (s[WW-1] != a[WW-1]);
    slot_i = 1'b1;
    acc_i  = a;
    casc_i = c[HW-1:0];          // R5 low half in slot clock
    @(posedge clk);
    @(negedge clk);
    casc_i = c[WW-1:HW];         // R5 high half next clock
    slot_i = hold;
    acc_i  = ~a;
    chk("R2", "outrdy low", {31'b0, outrdy_o}, 32'd0);
    chk("R9", "res_lo held", {20'b0, res_lo_o}, {20'b0, prev_lo});
    chk("R9", "res_hi held", {20'b0, res_hi_o}, {20'b0, prev_hi});
    if (primed) begin
      chk("R6", "low half", {20'b0, dout_o}, {20'b0, s[HW-1:0]});
      chk("R7", "ovf", {31'b0, ovf_o}, {31'b0, ov});
    end
    @(posedge clk);
    @(negedge clk);
    slot_i = 1'b0;
    casc_i = '0;
    chk(hold ? "R8" : "R3", "outrdy high", {31'b0, outrdy_o}, 32'd1);
    chk("R7", "ovf cleared", {31'b0, ovf_o}, 32'd0);
    if (primed) begin
      chk("R3", "high half", {20'b0, dout_o}, {20'b0, s[WW-1:HW]});
      chk("R3", "res_lo", {20'b0, res_lo_o}, {20'b0, s[HW-1:0]});
      chk("R3", "res_hi", {20'b0, res_hi_o}, {20'b0, s[WW-1:HW]});
    end else begin
      chk("R3", "res_hi matches port", {20'b0, res_hi_o}, {20'b0, dout_o});
    end
    prev_lo = res_lo_o;
    prev_hi = res_hi_o;
    for (int g = 0; g < gap; g++) begin
      logic [HW-1:0] d0;
      d0 = dout_o;
      @(posedge clk);
      @(negedge clk);
      chk("R4", "idle outrdy", {31'b0, outrdy_o}, 32'd1);
      chk("R4", "idle dout", {20'b0, dout_o}, {20'b0, d0});
      chk("R9", "idle res_lo", {20'b0, res_lo_o}, {20'b0, prev_lo});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "dout", {20'b0, dout_o}, 32'd0);
    chk("R1", "outrdy", {31'b0, outrdy_o}, 32'd1);
    chk("R1", "res_lo", {20'b0, res_lo_o}, 32'd0);
    chk("R1", "res_hi", {20'b0, res_hi_o}, 32'd0);
    chk("R1", "ovf", {31'b0, ovf_o}, 32'd0);
    rst = 1'b0;
    prev_lo = '0;
    prev_hi = '0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "after release", {31'b0, outrdy_o}, 32'd1);
    for (int n = 0; n < NSLOT; n++) begin
      run_slot(n, n % 3, (n % 4) == 1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule